// File: doc/BRIEF.md
# Auto-Baud Single-Wire Key Reporter

This block answers a host that asks for the state of ten touch keys over one shared, pulled-up serial wire. The host sends a single request character, either on the shared wire or on a separate receive-only pin. The block measures the bit period from the timing of that character, then drives a two-byte reply back on the shared wire at the same rate, and floats the wire again when it is done. The host never needs to tell the block its baud rate, and neither side needs an accurate clock.

An active-low change flag tells the host when a read is worth making. Any key press or release, signalled by a strobe beside the key state vector, pulls the flag low. The flag stays low until a request is accepted, so the host only polls when something new has happened. The key states are captured when the request is accepted, so the reply is one consistent snapshot even if the keys move while it is being sent.

All timing is in clock cycles. The accepted bit-period window and the reply gap are parameters. The two receive inputs are synchronized inside the block.

Top module: `onewire_key_reporter`

## Requirements
- R1: A request is the character 0x50 sent as 8 data bits LSB first, no parity, one stop bit (start 0, stop 1). It is accepted from either input, `line_i` or `rx_i`, and a low level on either one counts as low. Every accepted request produces exactly one reply on the shared wire.
- R2: The bit period is the length of the first low run of the request divided by 5. That run is the start bit plus data bits 0 to 3. A period below MIN_BIT_CYC or above MAX_BIT_CYC clock cycles gets no reply.
- R3: The reply is two frames sent back to back at the measured period. Each frame is a 0 start bit, 8 data bits LSB first, and a 1 stop bit.
- R4: Reply byte 0 is {bit7=0, bit6=1, keys[5:0]}. Reply byte 1 is {bit7=0, bit6=1, bits5:4=00, keys[9:6]}. With no keys active this gives 0x40, 0x40; with keys 0, 2 and 7 active it gives 0x45, 0x42.
- R5: The first start bit of the reply begins between 1 and 3 bit periods after the end of the request's stop bit. The default is GAP_BITS=2 periods counted from the middle of the stop bit.
- R6: `line_oe_o` is low out of reset and high only while the reply is sent. It drops right after the second stop bit has been driven for one bit period.
- R7: `change_n_o` is high out of reset. It goes low the cycle after `key_chg_i` is high, and stays low until a request is accepted. It is high again before the reply starts. A strobe in the same cycle as an acceptance keeps it low.
- R8: The key states go into the reply in the cycle the request is accepted. Later changes of `keys_i` do not affect that reply.
- R9: Nothing happens for a character other than 0x50, or for a request whose stop bit is 0: no reply, and no change to `change_n_o`. The receiver waits for the wire to return high and then accepts the next valid request.
- R10: Receive activity while a reply is in progress is ignored and produces no further reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Level of the shared serial wire |
| rx_i | input | 1 | Receive-only request pin, idle high |
| keys_i | input | 10 | Current key states, 1 = touched |
| key_chg_i | input | 1 | One-cycle strobe: some key changed state |
| line_o | output | 1 | Value driven onto the shared wire |
| line_oe_o | output | 1 | Drive enable for the shared wire, 0 = high impedance |
| change_n_o | output | 1 | Active-low flag: key states changed since the last reply |

## Verification
On every cycle, assertions check the change-flag rules (set on a strobe, held until a request is accepted, released at acceptance). They also check that the measured period always lies in the allowed window, that no request is accepted while a reply is running, that every reply opens with a low start bit, and that the drive enable falls only after a high stop level. Only the bench scenarios can show the rest: the actual reply bytes for many key patterns and rates, the reply delay, the snapshot behaviour when keys change mid-reply, and the silent rejection of wrong characters, bad stop bits and out-of-range rates, each followed by a working request.

// File: rtl/akr_pkg.sv
package akr_pkg;
  localparam int unsigned NUM_KEYS   = 10;
  localparam int unsigned FRAME_BITS = 20;
  // request bits d4..d7 stored at sh[0..3]
  localparam logic [3:0] REQ_HI_NIB = 4'b0101;

  typedef enum logic [1:0] {RX_IDLE, RX_LOW, RX_SAMP, RX_WAITHI} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_GAP, TX_SEND} tx_state_e;

  // two frames, LSB first: start, byte0, stop, start, byte1, stop
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [NUM_KEYS-1:0] k);
    logic [7:0] b0;
    logic [7:0] b1;
    b0 = {2'b01, k[5:0]};
    b1 = {2'b01, 2'b00, k[9:6]};
    return {1'b1, b1, 1'b0, 1'b1, b0, 1'b0};
  endfunction
endpackage

// File: rtl/akr_sync.sv
module akr_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '1;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/akr_rx.sv
module akr_rx
  import akr_pkg::*;
#(
  parameter int unsigned MIN_BIT_CYC = 8,
  parameter int unsigned MAX_BIT_CYC = 64,
  parameter int unsigned CNT_W       = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             busy_i,
  output logic             req_o,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_BIT_CYC);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_BIT_CYC);
  localparam logic [CNT_W-1:0] LOW_LIM = CNT_W'(MAX_BIT_CYC * 5 + 4);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, tmr_q, per_q, bit_est;
  logic [2:0]       idx_q;
  logic [3:0]       sh_q;

  // low run = start bit + four zero data bits
  assign bit_est = cnt_q / CNT_W'(5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      tmr_q   <= '0;
      per_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      req_o   <= 1'b0;
    end else begin
      req_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (!busy_i && !ser_i) begin
            state_q <= RX_LOW;
            cnt_q   <= CNT_W'(1);
          end
        end
        RX_LOW: begin
          if (!ser_i) begin
            if (cnt_q == LOW_LIM) state_q <= RX_WAITHI;
            else                  cnt_q   <= cnt_q + 1'b1;
          end else if (bit_est < MIN_C || bit_est > MAX_C) begin
            state_q <= RX_IDLE;
          end else begin
            per_q   <= bit_est;
            tmr_q   <= bit_est >> 1;
            idx_q   <= '0;
            state_q <= RX_SAMP;
          end
        end
        RX_SAMP: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (idx_q == 3'd4) begin
            if (sh_q == REQ_HI_NIB && ser_i) begin
              req_o   <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              state_q <= ser_i ? RX_IDLE : RX_WAITHI;
            end
          end else begin
            sh_q[idx_q[1:0]] <= ser_i;
            idx_q            <= idx_q + 1'b1;
            tmr_q            <= per_q - 1'b1;
          end
        end
        RX_WAITHI: if (ser_i) state_q <= RX_IDLE;
        default:   state_q <= RX_IDLE;
      endcase
    end
  end

  assign period_o = per_q;

  assert_period_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (period_o >= MIN_C && period_o <= MAX_C))
    else $error("period out of range");
endmodule

// File: rtl/akr_tx.sv
module akr_tx
  import akr_pkg::*;
#(
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned GAP_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    period_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  output logic                busy_o,
  output logic                line_o,
  output logic                oe_o
);
  localparam logic [4:0] LAST_BIT = 5'(FRAME_BITS - 1);
  localparam logic [4:0] GAP_LAST = 5'(GAP_BITS - 1);

  tx_state_e             state_q;
  logic [CNT_W-1:0]      tmr_q, per_q;
  logic [4:0]            bcnt_q;
  logic [FRAME_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      tmr_q   <= '0;
      per_q   <= '0;
      bcnt_q  <= '0;
      sh_q    <= '1;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (start_i) begin
            sh_q    <= build_frame(keys_i);  // snapshot at acceptance
            per_q   <= period_i;
            tmr_q   <= period_i - 1'b1;
            bcnt_q  <= '0;
            state_q <= TX_GAP;
          end
        end
        TX_GAP: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            tmr_q <= per_q - 1'b1;
            if (bcnt_q == GAP_LAST) begin
              bcnt_q  <= '0;
              state_q <= TX_SEND;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        TX_SEND: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (bcnt_q == LAST_BIT) begin
            state_q <= TX_IDLE;
          end else begin
            sh_q   <= sh_q >> 1;
            bcnt_q <= bcnt_q + 1'b1;
            tmr_q  <= per_q - 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != TX_IDLE);
  assign oe_o   = (state_q == TX_SEND);
  assign line_o = oe_o ? sh_q[0] : 1'b1;

  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !line_o)
    else $error("reply not opened by start bit");

  assert_release_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> $past(line_o))
    else $error("drive released without stop level");
endmodule

// File: rtl/onewire_key_reporter.sv
module onewire_key_reporter
  import akr_pkg::*;
#(
  parameter int unsigned MIN_BIT_CYC = 3255,
  parameter int unsigned MAX_BIT_CYC = 15625,
  parameter int unsigned GAP_BITS    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_i,
  input  logic                rx_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic                key_chg_i,
  output logic                line_o,
  output logic                line_oe_o,
  output logic                change_n_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BIT_CYC * 5 + 5);

  logic [1:0]       in_s;
  logic             ser;
  logic             req_ok;
  logic             tx_busy;
  logic [CNT_W-1:0] period;

  akr_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({line_i, rx_i}),
    .q_o   (in_s)
  );

  assign ser = in_s[1] & in_s[0];

  akr_rx #(
    .MIN_BIT_CYC(MIN_BIT_CYC),
    .MAX_BIT_CYC(MAX_BIT_CYC),
    .CNT_W      (CNT_W)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ser_i   (ser),
    .busy_i  (tx_busy),
    .req_o   (req_ok),
    .period_o(period)
  );

  akr_tx #(.CNT_W(CNT_W), .GAP_BITS(GAP_BITS)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req_ok),
    .period_i(period),
    .keys_i  (keys_i),
    .busy_o  (tx_busy),
    .line_o  (line_o),
    .oe_o    (line_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        change_n_o <= 1'b1;
    else if (key_chg_i) change_n_o <= 1'b0;
    else if (req_ok)    change_n_o <= 1'b1;
  end

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_chg_i |=> !change_n_o)
    else $error("flag not set on change");

  assert_flag_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && !key_chg_i) |=> change_n_o)
    else $error("flag not released on request");

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!change_n_o && !req_ok) |=> !change_n_o)
    else $error("flag released without request");

  assert_no_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |-> !tx_busy)
    else $error("request accepted during reply");
endmodule

// File: tb/onewire_key_reporter_tb.sv
module onewire_key_reporter_tb;
  localparam int MINB = 8;
  localparam int MAXB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_line = 1'b1;
  logic host_rx = 1'b1;
  logic [9:0] keys = '0;
  logic kchg = 1'b0;
  logic line_o, line_oe, change_n, line_in;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  assign line_in = line_oe ? line_o : host_line;

  onewire_key_reporter #(.MIN_BIT_CYC(MINB), .MAX_BIT_CYC(MAXB), .GAP_BITS(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line_in), .rx_i(host_rx),
    .keys_i(keys), .key_chg_i(kchg),
    .line_o(line_o), .line_oe_o(line_oe), .change_n_o(change_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_b0(input logic [9:0] k);
    return {2'b01, k[5:0]};
  endfunction

  function automatic logic [7:0] exp_b1(input logic [9:0] k);
    return {4'b0100, k[9:6]};
  endfunction

  task automatic strobe(input logic [9:0] k);
    keys = k;
    kchg = 1'b1;
    tick(1);
    kchg = 1'b0;
  endtask

  task automatic send_char(input bit on_rx, input logic [7:0] c, input int p, input bit stop);
    logic [9:0] f;
    f = {stop, c, 1'b0};
    for (int i = 0; i < 10; i++) begin
      if (on_rx) host_rx = f[i];
      else       host_line = f[i];
      tick(p);
    end
    host_rx = 1'b1;
    host_line = 1'b1;
  endtask

  task automatic get_reply(input int p, output logic [7:0] b0, output logic [7:0] b1, output bit got);
    int dly;
    logic [19:0] fr;
    dly = 0;
    got = 1'b0;
    b0 = '0;
    b1 = '0;
    fr = '0;
    while (!line_oe && dly < 6 * p) begin
      tick(1);
      dly++;
    end
    if (line_oe) begin
      got = 1'b1;
      chk(dly >= p && dly <= 3 * p, "R5 reply delay", dly, 2 * p);
      chk(change_n == 1'b1, "R7 flag high at reply start", change_n, 1);
      tick(p / 2);
      for (int i = 0; i < 20; i++) begin
        fr[i] = line_o;
        if (!line_oe) chk(1'b0, "R6 drive held through reply", i, 20);
        if (i < 19) tick(p);
      end
      tick(p / 2 + 2);
      chk(line_oe == 1'b0, "R6 release after stop", line_oe, 0);
      chk(fr[0] == 1'b0 && fr[9] && !fr[10] && fr[19], "R3 framing", int'(fr), 0);
      b0 = fr[8:1];
      b1 = fr[18:11];
    end
  endtask

  task automatic txn(input int p, input bit on_rx, input logic [9:0] k);
    logic [7:0] b0, b1;
    bit got;
    strobe(k);
    tick(2);
    send_char(on_rx, 8'h50, p, 1'b1);
    get_reply(p, b0, b1, got);
    chk(got, "R1 reply produced", got, 1);
    chk(b0 == exp_b0(k), "R4 byte0", b0, exp_b0(k));
    chk(b1 == exp_b1(k), "R4 byte1", b1, exp_b1(k));
    tick(p);
  endtask

  task automatic silence(input int n, input string tag);
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (line_oe) bad = 1'b1;
    end
    chk(!bad, tag, bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1;
    bit got;
    tick(5);
    chk(change_n == 1'b1, "R7 reset flag", change_n, 1);
    chk(line_oe == 1'b0, "R6 reset released", line_oe, 0);
    rst_n = 1'b1;
    tick(3);
    chk(line_oe == 1'b0, "R6 idle released", line_oe, 0);

    strobe(10'h000);
    chk(change_n == 1'b0, "R7 flag set by strobe", change_n, 0);
    tick(20);
    chk(change_n == 1'b0, "R7 flag held", change_n, 0);

    // R2 R3 rates across the window
    txn(8, 1'b0, 10'h000);
    txn(12, 1'b0, 10'h3FF);
    txn(20, 1'b0, 10'h085);   // R4 keys 0,2,7 -> 0x45 0x42
    chk(exp_b0(10'h085) == 8'h45 && exp_b1(10'h085) == 8'h42, "R4 example bytes", 0, 0);
    txn(33, 1'b0, 10'h2A5);
    txn(64, 1'b0, 10'h15A);

    // R4 pattern sweep at the fastest rate
    for (int i = 0; i < 28; i++) txn(8, 1'b0, 10'((i * 37) % 1024));
    txn(8, 1'b0, 10'h3FF);

    // R1 request on the receive-only pin
    txn(20, 1'b1, 10'h201);
    txn(9, 1'b1, 10'h0F0);

    // R9 invalid characters, bad stop; R2 out-of-range periods
    strobe(10'h003);
    send_char(1'b0, 8'h51, 20, 1'b1);
    silence(800, "R9 char 0x51 ignored");
    send_char(1'b0, 8'h70, 20, 1'b1);
    silence(800, "R9 char 0x70 ignored");
    send_char(1'b0, 8'h50, 20, 1'b0);
    silence(800, "R9 bad stop ignored");
    send_char(1'b0, 8'h50, 6, 1'b1);
    silence(800, "R2 period below window ignored");
    send_char(1'b0, 8'h50, 80, 1'b1);
    silence(3200, "R2 period above window ignored");
    chk(change_n == 1'b0, "R9 flag untouched by rejects", change_n, 0);
    txn(20, 1'b0, 10'h003);   // R9 rearmed

    // R8 snapshot; R7 strobe during reply re-asserts flag
    strobe(10'h155);
    tick(2);
    send_char(1'b0, 8'h50, 16, 1'b1);
    fork
      get_reply(16, b0, b1, got);
      begin
        while (!line_oe) tick(1);
        tick(48);
        strobe(10'h2AA);
      end
    join
    chk(got && b0 == exp_b0(10'h155), "R8 byte0 snapshot", b0, exp_b0(10'h155));
    chk(b1 == exp_b1(10'h155), "R8 byte1 snapshot", b1, exp_b1(10'h155));
    chk(change_n == 1'b0, "R7 flag set during reply", change_n, 0);
    tick(16);
    send_char(1'b0, 8'h50, 16, 1'b1);
    get_reply(16, b0, b1, got);
    chk(got && b0 == exp_b0(10'h2AA) && b1 == exp_b1(10'h2AA), "R8 new keys next reply",
        {b1, b0}, {exp_b1(10'h2AA), exp_b0(10'h2AA)});

    // R10 request on rx while replying is ignored
    strobe(10'h011);
    tick(2);
    send_char(1'b0, 8'h50, 10, 1'b1);
    fork
      get_reply(10, b0, b1, got);
      begin
        while (!line_oe) tick(1);
        tick(2);
        send_char(1'b1, 8'h50, 10, 1'b1);
      end
    join
    chk(got && b0 == exp_b0(10'h011), "R10 first reply intact", b0, exp_b0(10'h011));
    silence(400, "R10 no second reply");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule